// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold Requests

This block buffers audio samples between a host-side register port and a serial audio engine. It holds two independent queues of 32-bit words: one carries samples from the host towards the serial engine, the other carries captured samples from the serial engine back to the host. The host fills the transmit queue and drains the receive queue through single-word register accesses. The serial engine pops transmit words and pushes received words through a plain streaming handshake.

Each direction raises a sticky request flag when its fill level passes a programmable threshold. Software clears a flag by writing 0 to it, and the flag comes straight back if its condition still holds. The flags feed interrupt outputs gated by per-direction enables, or they can drive a DMA request line directly. Each queue has its own reset bit, and a soft reset bit empties both queues and clears every status flag. An audio clock enable bit is passed through to the clock logic outside the block.

Register selects on `reg_addr_i`: 0 control, 1 status, 2 transmit data (write), 3 receive data (read), 4 thresholds.

Top module: `audio_sample_fifo`

## Requirements
- R1: After reset, both queue counts are 0, every status flag is 0, the control and threshold registers read 0, `tx_valid_o` is 0, `rx_space_o` is 1, and `aclk_en_o` and both interrupt outputs are 0.
- R2: A write to transmit data appends a word to the transmit queue. The serial engine receives the words in write order on `tx_data_o`, one per `tx_pop_i` while `tx_valid_o` is high. The transmit count appears in status bits 29:24 and never exceeds 32.
- R3: Each `rx_push_i` appends `rx_data_i` to the receive queue. Reads of receive data return the words in arrival order and remove them. The receive count appears in status bits 13:8.
- R4: A transmit data write while the transmit queue holds 32 words is dropped. It sets the sticky transmit overrun flag (status bit 20, `tx_ovr_o`).
- R5: A receive data read while the receive queue is empty returns 0. It sets the sticky receive underrun flag (status bit 4, `rx_udr_o`).
- R6: The transmit request flag (status bit 16, `tx_req_o`) sets on the clock edge after the free space, 32 minus the count, exceeds the transmit threshold in threshold bits 12:8.
- R7: The receive request flag (status bit 0, `rx_req_o`) sets on the clock edge after the count exceeds the receive threshold in threshold bits 4:0. A threshold of 0 requests on the first sample.
- R8: Status flags are cleared by writing 0 to their bit. Writing 1 has no effect. A request flag stays set through a clearing write while its condition still holds.
- R9: While control bit 1 is held, the transmit queue is empty and drops writes and pops without setting overrun. While control bit 0 is held, the receive queue is empty and drops pushes; reads return 0 without setting underrun. The other queue is unaffected in each case.
- R10: While control bit 16 is held, both queues are empty and all status flags read 0.
- R11: `tx_irq_o` is the transmit request gated by control bit 3. `rx_irq_o` is the receive request gated by control bit 2.
- R12: `aclk_en_o` follows control bit 31. Control reads back only bits 31, 16 and 3:0. Threshold reads back only bits 12:8 and 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops receive data) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from select |
| tx_pop_i | input | 1 | Serial engine takes the head transmit word |
| tx_data_o | output | 32 | Head transmit word |
| tx_valid_o | output | 1 | Transmit queue not empty |
| rx_push_i | input | 1 | Serial engine delivers a received word |
| rx_data_i | input | 32 | Received word |
| rx_space_o | output | 1 | Receive queue not full |
| tx_req_o | output | 1 | Transmit request flag |
| rx_req_o | output | 1 | Receive request flag |
| tx_irq_o | output | 1 | Gated transmit interrupt |
| rx_irq_o | output | 1 | Gated receive interrupt |
| tx_ovr_o | output | 1 | Transmit overrun flag |
| rx_udr_o | output | 1 | Receive underrun flag |
| aclk_en_o | output | 1 | Audio clock enable |

## Verification
On every cycle, the assertions check the count bound and the threshold-to-flag relation in both directions. They also check that a write to a full queue yields overrun, that an empty read returns zero, that the held resets keep the queues and flags empty, and that a disabled interrupt stays low. Word ordering through each queue, the sweep of threshold and fill-level pairs, the write-0 clearing rules and the register read-back masks need the bench's scenarios. The bench also shows that resetting one queue leaves the other queue's contents alone.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_STAT = 3'd1,
    SEL_TXD  = 3'd2,
    SEL_RXD  = 3'd3,
    SEL_THR  = 3'd4
  } reg_sel_e;

  localparam int CTL_RX_RST = 0;
  localparam int CTL_TX_RST = 1;
  localparam int CTL_RX_IE  = 2;
  localparam int CTL_TX_IE  = 3;
  localparam int CTL_SOFT   = 16;
  localparam int CTL_ACLK   = 31;
  localparam logic [31:0] CTL_MASK = 32'h8001_000F;

  localparam int ST_RX_REQ = 0;
  localparam int ST_RX_UDR = 4;
  localparam int ST_RX_CNT = 8;
  localparam int ST_TX_REQ = 16;
  localparam int ST_TX_OVR = 20;
  localparam int ST_TX_CNT = 24;

  localparam int TH_RX = 0;
  localparam int TH_TX = 8;
endpackage

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter  int DEPTH = 32,
  parameter  int WIDTH = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/afifo_level.sv
module afifo_level #(
  parameter  int DEPTH     = 32,
  parameter  bit FREE_MODE = 1'b0,
  localparam int TW        = $clog2(DEPTH),
  localparam int CW        = TW + 1
) (
  input  logic [CW-1:0] count_i,
  input  logic [TW-1:0] thr_i,
  output logic          hit_o
);
  logic [CW-1:0] level;

  generate
    if (FREE_MODE) begin : g_free
      assign level = CW'(DEPTH) - count_i;
    end else begin : g_used
      assign level = count_i;
    end
  endgenerate

  assign hit_o = level > {1'b0, thr_i};
endmodule

// File: rtl/afifo_sticky.sv
module afifo_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= 1'b0;
    else if (flush_i) q <= 1'b0;
    else              q <= (q & ~clr_i) | set_i;
  end

  assign flag_o = q;
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo
  import audio_fifo_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int DW    = 32,
  localparam int TW    = $clog2(DEPTH),
  localparam int CW    = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          tx_pop_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_valid_o,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rx_space_o,
  output logic          tx_req_o,
  output logic          rx_req_o,
  output logic          tx_irq_o,
  output logic          rx_irq_o,
  output logic          tx_ovr_o,
  output logic          rx_udr_o,
  output logic          aclk_en_o
);
  logic [31:0]   ctrl_q;
  logic [TW-1:0] tx_thr_q, rx_thr_q;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0] rx_head;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic          tx_flush, rx_flush, soft_rst;
  logic          wr_ctrl, wr_stat, wr_txd, wr_thr, rd_rxd;
  logic          tx_hit, rx_hit;
  logic [31:0]   stat_w, thr_w;

  assign wr_ctrl = reg_wr_i & (reg_addr_i == SEL_CTRL);
  assign wr_stat = reg_wr_i & (reg_addr_i == SEL_STAT);
  assign wr_txd  = reg_wr_i & (reg_addr_i == SEL_TXD);
  assign wr_thr  = reg_wr_i & (reg_addr_i == SEL_THR);
  assign rd_rxd  = reg_rd_i & (reg_addr_i == SEL_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      tx_thr_q <= '0;
      rx_thr_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i & CTL_MASK;
      if (wr_thr) begin
        tx_thr_q <= reg_wdata_i[TH_TX +: TW];
        rx_thr_q <= reg_wdata_i[TH_RX +: TW];
      end
    end
  end

  assign soft_rst = ctrl_q[CTL_SOFT];
  assign tx_flush = ctrl_q[CTL_TX_RST] | soft_rst;
  assign rx_flush = ctrl_q[CTL_RX_RST] | soft_rst;

  afifo_mem #(.DEPTH(DEPTH), .WIDTH(DW)) u_tx_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (tx_flush),
    .push_i  (wr_txd),
    .wdata_i (reg_wdata_i[DW-1:0]),
    .pop_i   (tx_pop_i),
    .rdata_o (tx_data_o),
    .count_o (tx_cnt),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  afifo_mem #(.DEPTH(DEPTH), .WIDTH(DW)) u_rx_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (rx_flush),
    .push_i  (rx_push_i),
    .wdata_i (rx_data_i),
    .pop_i   (rd_rxd),
    .rdata_o (rx_head),
    .count_o (rx_cnt),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  afifo_level #(.DEPTH(DEPTH), .FREE_MODE(1'b1)) u_tx_lvl (
    .count_i (tx_cnt),
    .thr_i   (tx_thr_q),
    .hit_o   (tx_hit)
  );

  afifo_level #(.DEPTH(DEPTH), .FREE_MODE(1'b0)) u_rx_lvl (
    .count_i (rx_cnt),
    .thr_i   (rx_thr_q),
    .hit_o   (rx_hit)
  );

  afifo_sticky u_tx_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst),
    .set_i   (tx_hit),
    .clr_i   (wr_stat & ~reg_wdata_i[ST_TX_REQ]),
    .flag_o  (tx_req_o)
  );

  afifo_sticky u_rx_req (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst),
    .set_i   (rx_hit),
    .clr_i   (wr_stat & ~reg_wdata_i[ST_RX_REQ]),
    .flag_o  (rx_req_o)
  );

  afifo_sticky u_tx_ovr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst),
    .set_i   (wr_txd & tx_full & ~tx_flush),
    .clr_i   (wr_stat & ~reg_wdata_i[ST_TX_OVR]),
    .flag_o  (tx_ovr_o)
  );

  afifo_sticky u_rx_udr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (soft_rst),
    .set_i   (rd_rxd & rx_empty & ~rx_flush),
    .clr_i   (wr_stat & ~reg_wdata_i[ST_RX_UDR]),
    .flag_o  (rx_udr_o)
  );

  always_comb begin
    stat_w = '0;
    stat_w[ST_TX_CNT +: CW] = tx_cnt;
    stat_w[ST_RX_CNT +: CW] = rx_cnt;
    stat_w[ST_TX_REQ] = tx_req_o;
    stat_w[ST_TX_OVR] = tx_ovr_o;
    stat_w[ST_RX_REQ] = rx_req_o;
    stat_w[ST_RX_UDR] = rx_udr_o;
    thr_w = '0;
    thr_w[TH_TX +: TW] = tx_thr_q;
    thr_w[TH_RX +: TW] = rx_thr_q;
  end

  always_comb begin
    case (reg_addr_i)
      SEL_CTRL: reg_rdata_o = ctrl_q;
      SEL_STAT: reg_rdata_o = stat_w;
      SEL_THR:  reg_rdata_o = thr_w;
      SEL_RXD:  reg_rdata_o = rx_empty ? '0 : 32'(rx_head);
      default:  reg_rdata_o = '0;
    endcase
  end

  assign tx_valid_o = ~tx_empty;
  assign rx_space_o = ~rx_full;
  assign tx_irq_o   = tx_req_o & ctrl_q[CTL_TX_IE];
  assign rx_irq_o   = rx_req_o & ctrl_q[CTL_RX_IE];
  assign aclk_en_o  = ctrl_q[CTL_ACLK];
endmodule

// File: rtl/afifo_chk.sv
module afifo_chk
  import audio_fifo_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int TW    = $clog2(DEPTH),
  localparam int CW    = TW + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    reg_addr_i,
  input logic          reg_wr_i,
  input logic          reg_rd_i,
  input logic [31:0]   reg_rdata_o,
  input logic          tx_req_o,
  input logic          rx_req_o,
  input logic          tx_irq_o,
  input logic          tx_ovr_o,
  input logic          rx_udr_o,
  input logic [CW-1:0] tx_cnt_i,
  input logic [CW-1:0] rx_cnt_i,
  input logic [TW-1:0] tx_thr_i,
  input logic [TW-1:0] rx_thr_i,
  input logic          tx_rst_i,
  input logic          soft_i,
  input logic          tx_ie_i
);
  // R2
  tx_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(tx_cnt_i) <= DEPTH && int'(rx_cnt_i) <= DEPTH);

  // R4
  tx_overrun_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == SEL_TXD && int'(tx_cnt_i) == DEPTH && !tx_rst_i && !soft_i
    |=> tx_ovr_o);

  // R5
  rx_empty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i && reg_addr_i == SEL_RXD && rx_cnt_i == '0 |-> reg_rdata_o == '0);

  // R6
  tx_req_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_i && (DEPTH - int'(tx_cnt_i)) > int'(tx_thr_i) |=> tx_req_o);

  // R7
  rx_req_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_i && int'(rx_cnt_i) > int'(rx_thr_i) |=> rx_req_o);

  // R9
  tx_hold_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rst_i && $past(tx_rst_i) |-> tx_cnt_i == '0);

  // R10
  soft_hold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_i && $past(soft_i) |-> tx_cnt_i == '0 && rx_cnt_i == '0 && !tx_req_o
      && !rx_req_o && !tx_ovr_o && !rx_udr_o);

  // R11
  tx_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_ie_i |-> !tx_irq_o);
endmodule

bind audio_sample_fifo afifo_chk #(.DEPTH(DEPTH)) u_afifo_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .tx_req_o    (tx_req_o),
  .rx_req_o    (rx_req_o),
  .tx_irq_o    (tx_irq_o),
  .tx_ovr_o    (tx_ovr_o),
  .rx_udr_o    (rx_udr_o),
  .tx_cnt_i    (tx_cnt),
  .rx_cnt_i    (rx_cnt),
  .tx_thr_i    (tx_thr_q),
  .rx_thr_i    (rx_thr_q),
  .tx_rst_i    (ctrl_q[1]),
  .soft_i      (ctrl_q[16]),
  .tx_ie_i     (ctrl_q[3])
);

// File: tb/audio_sample_fifo_bench.sv
`timescale 1ns/100ps
module audio_sample_fifo_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_TXD = 3'd2, A_RXD = 3'd3, A_THR = 3'd4;

  typedef struct packed {
    logic [4:0] tthr;
    logic [4:0] rthr;
    logic [5:0] ntx;
    logic [5:0] nrx;
    logic       etx;
    logic       erx;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{tthr: 5'd0,  rthr: 5'd0,  ntx: 6'd0,  nrx: 6'd0,  etx: 1'b1, erx: 1'b0},
    '{tthr: 5'd15, rthr: 5'd0,  ntx: 6'd16, nrx: 6'd1,  etx: 1'b1, erx: 1'b1},
    '{tthr: 5'd16, rthr: 5'd3,  ntx: 6'd16, nrx: 6'd3,  etx: 1'b0, erx: 1'b0},
    '{tthr: 5'd31, rthr: 5'd4,  ntx: 6'd0,  nrx: 6'd5,  etx: 1'b1, erx: 1'b1},
    '{tthr: 5'd31, rthr: 5'd31, ntx: 6'd1,  nrx: 6'd31, etx: 1'b0, erx: 1'b0},
    '{tthr: 5'd0,  rthr: 5'd31, ntx: 6'd32, nrx: 6'd32, etx: 1'b0, erx: 1'b1},
    '{tthr: 5'd5,  rthr: 5'd10, ntx: 6'd27, nrx: 6'd11, etx: 1'b0, erx: 1'b1},
    '{tthr: 5'd4,  rthr: 5'd10, ntx: 6'd27, nrx: 6'd10, etx: 1'b1, erx: 1'b0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, tx_pop = 1'b0, rx_push = 1'b0;
  logic [31:0] wdata = '0, rx_data = '0, rdata, tx_data;
  logic        tx_valid, rx_space, tx_req, rx_req, tx_irq, rx_irq, tx_ovr, rx_udr, aclk_en;
  int          checks = 0, errors = 0, cyc = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  audio_sample_fifo u_audio_sample_fifo (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .rx_push_i(rx_push), .rx_data_i(rx_data), .rx_space_o(rx_space),
    .tx_req_o(tx_req), .rx_req_o(rx_req), .tx_irq_o(tx_irq), .rx_irq_o(rx_irq),
    .tx_ovr_o(tx_ovr), .rx_udr_o(rx_udr), .aclk_en_o(aclk_en)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles exp fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // all tasks start and end just after a negedge
  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic soft_reset();
    wr_reg(A_CTRL, 32'h0001_0000);
    wr_reg(A_CTRL, 32'h0);
  endtask

  task automatic rx_feed(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      rx_push = 1'b1; rx_data = base + 32'(i);
      @(negedge clk);
    end
    rx_push = 1'b0;
  endtask

  task automatic tx_fill(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) wr_reg(A_TXD, base + 32'(i));
  endtask

  initial begin
    idle(2);
    // R1 reset state
    peek(A_STAT, v);  check("R1 status", v, 32'h0);
    peek(A_CTRL, v);  check("R1 ctrl", v, 32'h0);
    peek(A_THR, v);   check("R1 thr", v, 32'h0);
    check("R1 outs", {tx_valid, rx_space, tx_req, rx_req, tx_irq, rx_irq, tx_ovr, rx_udr, aclk_en},
          9'b0_1000_0000);
    rst_n = 1'b1;
    idle(1);

    // R6 R7 threshold sweep
    for (int k = 0; k < NV; k++) begin
      soft_reset();
      wr_reg(A_THR, {19'b0, VECS[k].tthr, 3'b0, VECS[k].rthr});
      tx_fill(int'(VECS[k].ntx), 32'hA000_0000);
      rx_feed(int'(VECS[k].nrx), 32'h5000_0000);
      idle(1);
      wr_reg(A_STAT, 32'h0);
      idle(1);
      peek(A_STAT, v);
      check($sformatf("R2 vec%0d tx count", k), {26'b0, v[29:24]}, {26'b0, VECS[k].ntx});
      check($sformatf("R3 vec%0d rx count", k), {26'b0, v[13:8]}, {26'b0, VECS[k].nrx});
      check($sformatf("R6 vec%0d tx req", k), {31'b0, v[16]}, {31'b0, VECS[k].etx});
      check($sformatf("R7 vec%0d rx req", k), {31'b0, v[0]}, {31'b0, VECS[k].erx});
    end

    // R2 ordering
    soft_reset();
    tx_fill(3, 32'hA000_0000);
    peek(A_STAT, v); check("R2 count 3", {26'b0, v[29:24]}, 32'd3);
    for (int i = 0; i < 3; i++) begin
      check("R2 tx valid", {31'b0, tx_valid}, 32'd1);
      check("R2 tx order", tx_data, 32'hA000_0000 + 32'(i));
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    end
    check("R2 drained", {31'b0, tx_valid}, 32'd0);

    // R4 overrun
    soft_reset();
    tx_fill(32, 32'hB000_0000);
    check("R4 no ovr yet", {31'b0, tx_ovr}, 32'd0);
    wr_reg(A_TXD, 32'hDEAD_BEEF);
    peek(A_STAT, v);
    check("R4 ovr bit", {31'b0, v[20]}, 32'd1);
    check("R4 ovr port", {31'b0, tx_ovr}, 32'd1);
    check("R4 count", {26'b0, v[29:24]}, 32'd32);
    for (int i = 0; i < 32; i++) begin
      if (i == 31) check("R4 last word kept", tx_data, 32'hB000_001F);
      tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
    end
    check("R4 empty after drain", {31'b0, tx_valid}, 32'd0);

    // R3 rx ordering
    soft_reset();
    rx_feed(3, 32'h5000_0000);
    for (int i = 0; i < 3; i++) begin
      rd_reg(A_RXD, v);
      check("R3 rx order", v, 32'h5000_0000 + 32'(i));
    end
    peek(A_STAT, v); check("R3 rx count 0", {26'b0, v[13:8]}, 32'd0);

    // R5 underrun
    rd_reg(A_RXD, v);
    check("R5 empty read", v, 32'h0);
    peek(A_STAT, v);
    check("R5 udr bit", {31'b0, v[4]}, 32'd1);
    check("R5 udr port", {31'b0, rx_udr}, 32'd1);

    // R8 clearing
    wr_reg(A_STAT, 32'hFFFF_FFFF);
    check("R8 write 1 keeps udr", {31'b0, rx_udr}, 32'd1);
    wr_reg(A_STAT, 32'h0);
    check("R8 write 0 clears udr", {31'b0, rx_udr}, 32'd0);
    wr_reg(A_THR, 32'h0);
    wr_reg(A_STAT, 32'h0);
    check("R7 thr0 empty no req", {31'b0, rx_req}, 32'd0);
    rx_feed(1, 32'h7777_0000);
    idle(1);
    check("R7 thr0 first sample", {31'b0, rx_req}, 32'd1);
    wr_reg(A_STAT, 32'h0);
    check("R8 resets while held", {31'b0, rx_req}, 32'd1);
    rd_reg(A_RXD, v);
    check("R3 single word", v, 32'h7777_0000);
    wr_reg(A_STAT, 32'h0);
    check("R8 cleared when cond gone", {31'b0, rx_req}, 32'd0);
    wr_reg(A_STAT, 32'h0000_0001);
    check("R8 write 1 no set", {31'b0, rx_req}, 32'd0);

    // R11 interrupt gating
    check("R11 tx irq off", {31'b0, tx_irq}, 32'd0);
    wr_reg(A_CTRL, 32'h0000_0008);
    check("R11 tx irq on", {30'b0, tx_irq, rx_irq}, 32'b10);
    rx_feed(1, 32'h1);
    idle(1);
    check("R11 rx irq gated", {31'b0, rx_irq}, 32'd0);
    wr_reg(A_CTRL, 32'h0000_0004);
    check("R11 rx irq on", {30'b0, tx_irq, rx_irq}, 32'b01);
    wr_reg(A_CTRL, 32'h0);

    // R9 per-queue reset
    soft_reset();
    tx_fill(2, 32'hC000_0000);
    rx_feed(2, 32'hD000_0000);
    wr_reg(A_CTRL, 32'h0000_0002);
    idle(1);
    peek(A_STAT, v);
    check("R9 tx held empty", {26'b0, v[29:24]}, 32'd0);
    check("R9 rx kept", {26'b0, v[13:8]}, 32'd2);
    wr_reg(A_TXD, 32'h1234_5678);
    peek(A_STAT, v);
    check("R9 tx write dropped", {26'b0, v[29:24]}, 32'd0);
    check("R9 no ovr", {31'b0, tx_ovr}, 32'd0);
    check("R9 tx not valid", {31'b0, tx_valid}, 32'd0);
    wr_reg(A_CTRL, 32'h0000_0001);
    idle(1);
    rx_feed(1, 32'hEEEE_0000);
    peek(A_STAT, v);
    check("R9 rx held empty", {26'b0, v[13:8]}, 32'd0);
    rd_reg(A_RXD, v);
    check("R9 rx read zero", v, 32'h0);
    check("R9 no udr", {31'b0, rx_udr}, 32'd0);
    wr_reg(A_CTRL, 32'h0);

    // R10 soft reset
    tx_fill(32, 32'h0);
    wr_reg(A_TXD, 32'h0);
    rx_feed(2, 32'h0);
    idle(1);
    check("R10 ovr before", {31'b0, tx_ovr}, 32'd1);
    wr_reg(A_CTRL, 32'h0001_0000);
    idle(1);
    peek(A_STAT, v);
    check("R10 status cleared", v, 32'h0);
    wr_reg(A_CTRL, 32'h0);

    // R12 control read-back and clock enable
    wr_reg(A_CTRL, 32'hFFFF_FFFF);
    peek(A_CTRL, v);
    check("R12 ctrl mask", v, 32'h8001_000F);
    check("R12 aclk on", {31'b0, aclk_en}, 32'd1);
    wr_reg(A_CTRL, 32'h0);
    check("R12 aclk off", {31'b0, aclk_en}, 32'd0);
    wr_reg(A_THR, 32'hFFFF_FFFF);
    peek(A_THR, v);
    check("R12 thr mask", v, 32'h0000_1F1F);

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule